// File: doc/BRIEF.md
# Delay-Line Modulation Tap Controller

This block picks the tap of a 384-tap clock delay line, laid out as a multiplexer matrix of 24 rows by 16 columns. It moves the selection once per reference clock so that the delayed clock is frequency modulated. A signed step is added to a tap pointer on every enabled cycle. The sign of the step follows a triangular profile: the pointer climbs for a programmed number of cycles, then falls for the same number, and this repeats. The step size sets the frequency deviation. The leg length sets the modulation rate.

The delay line covers only one period of the incoming clock. A calibrated taps-per-period count is supplied from outside. When the pointer would run past that count, one whole period of taps is removed. When it would go below zero, one period is added. The pointer therefore wraps instead of stopping at an end, and a sustained frequency offset is possible. The pointer leaves the block as a row index and a column index for the multiplexer.

The sequencing is a three-state machine:
- `S_IDLE`: the block is disabled or in reset, and the pointer is 0.
- `S_RISE`: the pointer moves up.
- `S_FALL`: the pointer moves down.

The transitions are:
- *start*: `S_IDLE` to `S_RISE` on the first enabled cycle, or straight to `S_FALL` when the leg is one cycle long.
- *peak*: `S_RISE` to `S_FALL` after a full leg.
- *trough*: `S_FALL` to `S_RISE` after a full leg.
- *stop*: any state to `S_IDLE` when enable is low or reset is high.

Top module: `dlmod_tap_ctrl`

## Requirements
- R1: On each clock edge where `rst` is high or `enable` is low, the pointer returns to tap 0 (`row_sel`=0, `col_sel`=0) and `dir_down` returns to 0 (next move is upward).
- R2: On each enabled edge in an upward leg, the pointer rises by the effective step when the result stays below the effective taps-per-period.
- R3: An upward move whose sum is greater than or equal to the effective taps-per-period produces the sum minus the taps-per-period.
- R4: A downward move whose difference is negative produces the difference plus the taps-per-period.
- R5: Each leg holds exactly the effective leg length in moves: `cfg_leg_len`, with 0 treated as 1. The first leg after enable goes upward. `dir_down` is 1 exactly when the next move goes downward.
- R6: `row_sel` is the pointer divided by 16 and `col_sel` is the pointer modulo 16. Both change on the same edge.
- R7: A `cfg_taps_per_period` above 384 acts as 384, and a value of 0 acts as 1.
- R8: A step greater than or equal to the effective taps-per-period acts as taps-per-period minus 1. A zero effective step holds the pointer constant.
- R9: With the configuration held constant since enable, the pointer always stays below the effective taps-per-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one pointer update per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs modulation when high; forces tap 0 when low |
| cfg_taps_per_period | input | 10 | Calibrated taps in one input clock period |
| cfg_step | input | 9 | Tap step magnitude per update (deviation) |
| cfg_leg_len | input | 16 | Updates per ramp leg (rate) |
| row_sel | output | 5 | Multiplexer row index |
| col_sel | output | 4 | Multiplexer column index |
| dir_down | output | 1 | 1 when the next update moves the pointer downward |

## Verification
The bench sweeps the taps-per-period over small, odd, mid-range, full and out-of-range values, including 0 and values above 384. For each, it crosses these with steps ranging from zero through the largest legal value to oversize, and with leg lengths of 0, 1, 3 and 10. Small periods with large steps force a wrap on almost every move, which separates the upward-wrap arithmetic from the downward-wrap arithmetic. Out-of-range periods and steps show whether the clamps act. One-cycle legs make the direction alternate every move, which exposes off-by-one errors in the leg counter. Longer legs separate plain ramping from wrapping.

// File: rtl/dlmod_pkg.sv
package dlmod_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RISE = 2'd1,
        S_FALL = 2'd2
    } leg_state_e;

endpackage

// File: rtl/dlmod_cfg_clamp.sv
module dlmod_cfg_clamp #(
    parameter int TAPS   = 384,
    parameter int TPP_W  = 10,
    parameter int STEP_W = 9,
    parameter int PTR_W  = 9
) (
    input  logic [TPP_W-1:0]  tpp_in,
    input  logic [STEP_W-1:0] step_in,
    output logic [PTR_W:0]    tpp_eff,
    output logic [PTR_W-1:0]  step_eff
);

    always_comb begin
        if (int'(tpp_in) == 0) begin
            tpp_eff = (PTR_W+1)'(1);
        end else if (int'(tpp_in) > TAPS) begin
            tpp_eff = (PTR_W+1)'(TAPS);
        end else begin
            tpp_eff = (PTR_W+1)'(tpp_in);
        end
    end

    always_comb begin
        if (int'(step_in) >= int'(tpp_eff)) begin
            step_eff = PTR_W'(int'(tpp_eff) - 1);
        end else begin
            step_eff = PTR_W'(step_in);
        end
    end

endmodule

// File: rtl/dlmod_ramp_fsm.sv
module dlmod_ramp_fsm
    import dlmod_pkg::*;
#(
    parameter int LEG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [LEG_W-1:0] leg_len,
    output leg_state_e       state,
    output logic             move_down
);

    logic [LEG_W-1:0] leg_eff;
    logic [LEG_W-1:0] cnt, cnt_n;
    logic [LEG_W:0]   cnt_inc;
    logic             leg_done;
    leg_state_e       state_n;

    assign leg_eff   = (leg_len == '0) ? LEG_W'(1) : leg_len;
    assign cnt_inc   = {1'b0, cnt} + (LEG_W+1)'(1);
    assign leg_done  = (cnt_inc >= {1'b0, leg_eff});
    assign move_down = (state == S_FALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_IDLE: begin
                state_n = leg_done ? S_FALL : S_RISE;
                cnt_n   = leg_done ? '0 : cnt_inc[LEG_W-1:0];
            end
            S_RISE: begin
                state_n = leg_done ? S_FALL : S_RISE;
                cnt_n   = leg_done ? '0 : cnt_inc[LEG_W-1:0];
            end
            S_FALL: begin
                state_n = leg_done ? S_RISE : S_FALL;
                cnt_n   = leg_done ? '0 : cnt_inc[LEG_W-1:0];
            end
            default: begin
                state_n = S_IDLE;
                cnt_n   = '0;
            end
        endcase
        if (!enable) begin
            state_n = S_IDLE;
            cnt_n   = '0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state == S_IDLE));

    assert_peak_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && state == S_RISE && leg_done) |=> (state == S_FALL));

    assert_trough_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && state == S_FALL && leg_done) |=> (state == S_RISE));

endmodule

// File: rtl/dlmod_tap_accum.sv
module dlmod_tap_accum #(
    parameter int TAPS  = 384,
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             move_down,
    input  logic [PTR_W-1:0] step_eff,
    input  logic [PTR_W:0]   tpp_eff,
    output logic [PTR_W-1:0] ptr
);

    localparam int SW = PTR_W + 2;

    logic signed [SW-1:0] raw, tpp_s, wrapped;

    assign tpp_s = $signed({1'b0, tpp_eff});

    always_comb begin
        if (move_down) begin
            raw = $signed({2'b00, ptr}) - $signed({2'b00, step_eff});
        end else begin
            raw = $signed({2'b00, ptr}) + $signed({2'b00, step_eff});
        end
        if (raw >= tpp_s) begin
            wrapped = raw - tpp_s;
        end else if (raw < 0) begin
            wrapped = raw + tpp_s;
        end else begin
            wrapped = raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ptr <= '0;
        end else begin
            ptr <= wrapped[PTR_W-1:0];
        end
    end

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (ptr == '0));

    assert_zero_step_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && step_eff == '0) |=> $stable(ptr));

    assert_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (enable && step_eff != '0) |=> (ptr != $past(ptr)));

    assert_below_period_R9: assert property (@(posedge clk) disable iff (rst)
        (enable && {1'b0, ptr} < tpp_eff) |=>
            (!$stable(tpp_eff) || {1'b0, ptr} < tpp_eff));

    assert_in_line_R9: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < TAPS);

endmodule

// File: rtl/dlmod_tap_decode.sv
module dlmod_tap_decode #(
    parameter int COLS  = 16,
    parameter int PTR_W = 9,
    parameter int ROW_W = 5,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] ptr,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);

    generate
        if ((1 << COL_W) == COLS) begin : g_pow2
            assign row = ROW_W'(ptr >> COL_W);
            assign col = ptr[COL_W-1:0];
        end else begin : g_div
            assign row = ROW_W'(int'(ptr) / COLS);
            assign col = COL_W'(int'(ptr) % COLS);
        end
    endgenerate

    assert_split_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(row) * COLS + int'(col)) == int'(ptr));

    assert_col_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(col) < COLS);

endmodule

// File: rtl/dlmod_tap_ctrl.sv
module dlmod_tap_ctrl
    import dlmod_pkg::*;
#(
    parameter int ROWS   = 24,
    parameter int COLS   = 16,
    parameter int TPP_W  = 10,
    parameter int STEP_W = 9,
    parameter int LEG_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic [TPP_W-1:0]          cfg_taps_per_period,
    input  logic [STEP_W-1:0]         cfg_step,
    input  logic [LEG_W-1:0]          cfg_leg_len,
    output logic [$clog2(ROWS)-1:0]   row_sel,
    output logic [$clog2(COLS)-1:0]   col_sel,
    output logic                      dir_down
);

    localparam int TAPS  = ROWS * COLS;
    localparam int PTR_W = $clog2(TAPS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    logic [PTR_W:0]   tpp_eff;
    logic [PTR_W-1:0] step_eff;
    logic [PTR_W-1:0] ptr;
    logic             move_down;
    leg_state_e       state;

    dlmod_cfg_clamp #(
        .TAPS(TAPS), .TPP_W(TPP_W), .STEP_W(STEP_W), .PTR_W(PTR_W)
    ) u_clamp (
        .tpp_in(cfg_taps_per_period),
        .step_in(cfg_step),
        .tpp_eff(tpp_eff),
        .step_eff(step_eff)
    );

    dlmod_ramp_fsm #(.LEG_W(LEG_W)) u_fsm (
        .clk(clk),
        .rst(rst),
        .enable(enable),
        .leg_len(cfg_leg_len),
        .state(state),
        .move_down(move_down)
    );

    dlmod_tap_accum #(.TAPS(TAPS), .PTR_W(PTR_W)) u_accum (
        .clk(clk),
        .rst(rst),
        .enable(enable),
        .move_down(move_down),
        .step_eff(step_eff),
        .tpp_eff(tpp_eff),
        .ptr(ptr)
    );

    dlmod_tap_decode #(
        .COLS(COLS), .PTR_W(PTR_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_decode (
        .clk(clk),
        .rst(rst),
        .ptr(ptr),
        .row(row_sel),
        .col(col_sel)
    );

    assign dir_down = (state == S_FALL);

    assert_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(tpp_eff) >= 1) && (int'(tpp_eff) <= TAPS));

    assert_step_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        int'(step_eff) < int'(tpp_eff));

endmodule

// File: tb/dlmod_tap_ctrl_bench.sv
module dlmod_tap_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [9:0] cfg_taps_per_period = '0;
    logic [8:0] cfg_step = '0;
    logic [15:0] cfg_leg_len = '0;
    logic [4:0] row_sel;
    logic [3:0] col_sel;
    logic       dir_down;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dlmod_tap_ctrl u_dlmod_tap_ctrl (
        .clk(clk),
        .rst(rst),
        .enable(enable),
        .cfg_taps_per_period(cfg_taps_per_period),
        .cfg_step(cfg_step),
        .cfg_leg_len(cfg_leg_len),
        .row_sel(row_sel),
        .col_sel(col_sel),
        .dir_down(dir_down)
    );

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, int'(row_sel), 0);
        check(req, int'(col_sel), 0);
        check(req, int'(dir_down), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    int tpps[8]  = '{0, 1, 5, 17, 100, 384, 500, 1023};
    int steps[8] = '{0, 1, 3, 7, 16, 99, 383, 400};
    int legs[4]  = '{0, 1, 3, 10};

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;

        foreach (tpps[i]) begin
            foreach (steps[j]) begin
                foreach (legs[k]) begin
                    int tpp_e, st_e, leg_e, p, c, s;
                    bit down;
                    string tag;
                    tpp_e = (tpps[i] == 0) ? 1 : ((tpps[i] > 384) ? 384 : tpps[i]);
                    st_e  = (steps[j] >= tpp_e) ? tpp_e - 1 : steps[j];
                    leg_e = (legs[k] == 0) ? 1 : legs[k];
                    p = 0; c = 0; down = 0;
                    cfg_taps_per_period = 10'(tpps[i]);
                    cfg_step = 9'(steps[j]);
                    cfg_leg_len = 16'(legs[k]);
                    enable = 1'b1;
                    for (int n = 0; n < 30; n++) begin
                        @(negedge clk);
                        s = down ? p - st_e : p + st_e;
                        tag = (st_e == 0) ? "R8" : "R2";
                        if (s >= tpp_e) begin
                            s = s - tpp_e; tag = "R3";
                        end else if (s < 0) begin
                            s = s + tpp_e; tag = "R4";
                        end
                        p = s;
                        c++;
                        if (c >= leg_e) begin
                            c = 0; down = !down;
                        end
                        check(tag, int'(row_sel) * 16 + int'(col_sel), p);
                        check("R6", int'(row_sel), p / 16);
                        check("R6", int'(col_sel), p % 16);
                        check("R5", int'(dir_down), int'(down));
                        check("R9", int'((int'(row_sel) * 16 + int'(col_sel)) < tpp_e), 1);
                        if (tpps[i] == 0 || tpps[i] > 384)
                            check("R7", int'(row_sel) * 16 + int'(col_sel), p);
                    end
                    enable = 1'b0;
                    @(negedge clk);
                    check_idle("R1");
                end
            end
        end

        cfg_taps_per_period = 10'd384;
        cfg_step = 9'd5;
        cfg_leg_len = 16'd100;
        enable = 1'b1;
        repeat (6) @(negedge clk);
        check("R2", int'(row_sel) * 16 + int'(col_sel), 30);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check("R2", int'(row_sel) * 16 + int'(col_sel), 5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule